// File: doc/BRIEF.md
# Timer Capture/Compare Channel

This block is one channel of a general-purpose timer. It does not own a counter. It watches a shared free-running count that arrives as an input. It also watches a counter-overflow pulse and an indication that the timer is halted. A four-bit control code selects the channel's function:

- **Pin parked:** the pin is handed back to port logic, and the channel keeps a chosen idle level ready.
- **Capture:** the count is recorded when the selected edge appears on the pin.
- **Compare:** the pin is toggled, cleared or set when the count reaches the channel value.
- **Double-buffered compare:** a new compare value only takes effect at the next counter overflow, so PWM duty can change without glitches.

Software uses a single write port. One select line steers a write either to the control code or to the channel value. Both are visible on read outputs. The event flag is raised by a capture or a compare match. It is cleared by software, either through a strobe or by writing the channel value.

Top module: `tmr_chan`

## Requirements
- R1: After reset the control code reads 0, the flag is low, `pin_oe` is low, `pin_out` is high and `rd_value` reads 0.
- R2: When control bits [1:0] are 00, the channel is parked. `pin_oe` stays low, and one cycle after the code is stored `pin_out` equals the inverse of bit [2] (bit 2 = 1 gives low, 0 gives high). Bit [3] is ignored.
- R3: With bits [3:2] = 00, the channel captures. Code [1:0] = 01 reacts to rising edges only, 10 to falling edges only and 11 to both. The pin passes two synchronising flops. The count present at the third rising clock edge after the pin changes is stored in the value register, and the flag is set at that edge. `pin_oe` stays low.
- R4: With bits [3:2] = 01, the channel compares. On a clock edge where the count equals the value register, the output toggles (01), clears (10) or sets (11), and `pin_oe` is high.
- R5: With bit [3] = 1 (bit 2 ignored), the channel runs buffered compare with the same actions as R4. A value write lands in the inactive register, and `rd_value` and the compare keep using the active one. At the next edge with `cnt_ovf` high, the newly written register becomes active. A control write made while halted selects the first register as active.
- R6: Control bits [3:2] change only on a control write made while `timer_halt` is high. Otherwise they keep their value, while bits [1:0] still take the written value.
- R7: A capture or a compare match sets the flag. `flag_clr` or a value write clears it. If a set and a clear fall on the same edge, the set wins.
- R8: On entry to compare mode, the output keeps the level the parked configuration left. It changes only on a match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 selects control code (data bits [3:0]), 1 selects channel value |
| wr_data | input | CW | Write data |
| flag_clr | input | 1 | Flag clear strobe |
| timer_halt | input | 1 | Timer stopped and reset; permits mode changes |
| cnt | input | CW | Shared counter value |
| cnt_ovf | input | 1 | Counter overflow pulse |
| pin_in | input | 1 | Asynchronous pin level |
| pin_out | output | 1 | Pin drive level |
| pin_oe | output | 1 | Pin drive enable |
| flag | output | 1 | Channel event flag |
| rd_ctrl | output | 4 | Control code readback |
| rd_value | output | CW | Active channel value |

## Verification
**Capture.** Each capture code is given both a rising and a falling pin transition. The count is held at a distinct value for each, so the stored value and the flag show which edges each code accepts.

**Compare.** Compare is driven with counts just below, at and just past the channel value. This separates the toggle, clear and set actions from a spurious match, and it starts from both parked levels so the entry level is seen.

**Buffered compare.** The buffered path is given a match on the pending value before and after an overflow pulse. This distinguishes a write that takes effect at once from one deferred to the overflow.

**Mode-bit protection.** A control write with and without the halt indication shows whether the mode bits are protected.

// File: rtl/tmr_chan.sv
module tmr_chan #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          wr_sel,
  input  logic [CW-1:0] wr_data,
  input  logic          flag_clr,
  input  logic          timer_halt,
  input  logic [CW-1:0] cnt,
  input  logic          cnt_ovf,
  input  logic          pin_in,
  output logic          pin_out,
  output logic          pin_oe,
  output logic          flag,
  output logic [3:0]    rd_ctrl,
  output logic [CW-1:0] rd_value
);

  logic          mb, ma;
  logic [1:0]    el;
  logic [CW-1:0] vreg [2];
  logic          act, pend;
  logic [2:0]    sy;
  logic          out_q, flag_q;

  wire parked   = (el == 2'b00);
  wire cap_mode = !parked && !mb && !ma;
  wire cmp_mode = !parked && (mb || ma);
  wire rise     = sy[1] & ~sy[2];
  wire fall     = ~sy[1] & sy[2];
  wire cap_evt  = cap_mode && ((el[0] && rise) || (el[1] && fall));
  wire wr_ctl   = wr_en && !wr_sel;
  wire wr_val   = wr_en && wr_sel;
  wire wsel     = mb ? ~act : 1'b0;
  wire [CW-1:0] act_val = mb ? vreg[act] : vreg[0];
  wire match    = cmp_mode && (cnt == act_val);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mb <= 1'b0;
      ma <= 1'b0;
      el <= 2'b00;
    end else if (wr_ctl) begin
      el <= wr_data[1:0];
      if (timer_halt) begin
        mb <= wr_data[3];
        ma <= wr_data[2];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sy <= '0;
    else        sy <= {sy[1:0], pin_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vreg[0] <= '0;
      vreg[1] <= '0;
    end else begin
      if (wr_val)  vreg[wsel] <= wr_data;
      if (cap_evt) vreg[0]    <= cnt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act  <= 1'b0;
      pend <= 1'b0;
    end else if (wr_ctl && timer_halt) begin
      act  <= 1'b0;
      pend <= 1'b0;
    end else begin
      if (mb && cnt_ovf && pend) begin
        act  <= ~act;
        pend <= 1'b0;
      end
      if (mb && wr_val) pend <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_q <= 1'b1;
    else if (parked) out_q <= ~ma;
    else if (match) begin
      case (el)
        2'b01:   out_q <= ~out_q;
        2'b10:   out_q <= 1'b0;
        default: out_q <= 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    flag_q <= 1'b0;
    else if (cap_evt || match)     flag_q <= 1'b1;
    else if (flag_clr || wr_val)   flag_q <= 1'b0;
  end

  assign pin_out  = out_q;
  assign pin_oe   = cmp_mode;
  assign flag     = flag_q;
  assign rd_ctrl  = {mb, ma, el};
  assign rd_value = act_val;

  p_park_level_r2: assert property (@(posedge clk) disable iff (!rst_n)
    parked |=> (pin_out == !$past(ma)));

  p_capture_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt |=> (flag && vreg[0] == $past(cnt)));

  p_set_action_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (match && el == 2'b11) |=> pin_out);

  p_swap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mb && cnt_ovf && pend && !wr_ctl) |=> (act != $past(act)));

  p_mode_guard_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_ctl && timer_halt) |=> $stable({mb, ma}));

  p_flag_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr && !cap_evt && !match) |=> !flag);

endmodule

// File: tb/tmr_chan_test.sv
module tmr_chan_test;
  localparam int CW = 16;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 0, rst_n = 0;
  logic wr_en = 0, wr_sel = 0, flag_clr = 0, timer_halt = 0, cnt_ovf = 0, pin_in = 0;
  logic [CW-1:0] wr_data = '0, cnt = '0;
  logic pin_out, pin_oe, flag;
  logic [3:0] rd_ctrl;
  logic [CW-1:0] rd_value;
  int checks = 0, errors = 0;

  tmr_chan #(.CW(CW)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .flag_clr(flag_clr), .timer_halt(timer_halt), .cnt(cnt), .cnt_ovf(cnt_ovf),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .flag(flag),
    .rd_ctrl(rd_ctrl), .rd_value(rd_value));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic tick(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic chk(string req, logic [31:0] actual, logic [31:0] expected);
    checks++;
    if (actual !== expected) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, actual, expected);
    end
  endtask

  task automatic wr_ctrl(logic [3:0] code, logic halt);
    wr_en = 1; wr_sel = 0; wr_data = CW'(code); timer_halt = halt;
    tick();
    wr_en = 0; timer_halt = 0;
  endtask

  task automatic wr_val(logic [CW-1:0] v);
    wr_en = 1; wr_sel = 1; wr_data = v;
    tick();
    wr_en = 0;
  endtask

  task automatic t_reset;
    chk("R1 ctrl", rd_ctrl, 0);
    chk("R1 flag", flag, 0);
    chk("R1 oe", pin_oe, 0);
    chk("R1 out", pin_out, 1);
    chk("R1 value", rd_value, 0);
  endtask

  task automatic t_park;
    wr_ctrl(4'b0100, 1); tick();
    chk("R2 low level", pin_out, 0);
    chk("R2 oe", pin_oe, 0);
    wr_ctrl(4'b1000, 1); tick();
    chk("R2 high level, bit3 ignored", pin_out, 1);
    chk("R2 oe", pin_oe, 0);
  endtask

  task automatic t_capture;
    for (int c = 1; c < 4; c++) begin
      wr_ctrl(4'(c), 1);
      pin_in = 0; tick(4);
      wr_val(16'h0000);
      cnt = 16'h1100 + 16'(c);
      pin_in = 1; tick(2);
      chk("R3 no early capture", flag, 0);
      tick();
      chk("R3 rising flag", flag, (c & 1) != 0);
      chk("R3 rising value", rd_value, (c & 1) ? cnt : 0);
      chk("R3 oe low", pin_oe, 0);
      wr_val(16'h0000);
      cnt = 16'h2200 + 16'(c);
      pin_in = 0; tick(3);
      chk("R3 falling flag", flag, (c & 2) != 0);
      chk("R3 falling value", rd_value, (c & 2) ? cnt : 0);
      cnt = 0;
    end
  endtask

  task automatic t_compare;
    cnt = 0;
    wr_ctrl(4'b0000, 1); tick();
    wr_val(16'd10);
    wr_ctrl(4'b0101, 1);
    chk("R8 entry level high", pin_out, 1);
    chk("R4 oe", pin_oe, 1);
    cnt = 9; tick();
    chk("R4 no match", pin_out, 1);
    cnt = 10; tick();
    chk("R4 toggle", pin_out, 0);
    chk("R7 match flag", flag, 1);
    cnt = 11; tick();
    chk("R4 past match", pin_out, 0);
    flag_clr = 1; tick(); flag_clr = 0;
    chk("R7 strobe clear", flag, 0);
    cnt = 0;
    wr_ctrl(4'b0111, 1);
    cnt = 10; tick(); cnt = 0;
    chk("R4 set", pin_out, 1);
    wr_val(16'd10);
    chk("R7 write clear", flag, 0);
    wr_ctrl(4'b0110, 1);
    cnt = 10; flag_clr = 1; tick(); cnt = 0; flag_clr = 0;
    chk("R4 clear", pin_out, 0);
    chk("R7 set wins", flag, 1);
    wr_ctrl(4'b0100, 1); tick();
    wr_ctrl(4'b0111, 1); tick();
    chk("R8 entry level low", pin_out, 0);
  endtask

  task automatic t_guard;
    wr_ctrl(4'b0101, 1);
    wr_ctrl(4'b1010, 0);
    chk("R6 mode held", rd_ctrl, 4'b0110);
    wr_ctrl(4'b1010, 1);
    chk("R6 mode taken", rd_ctrl, 4'b1010);
  endtask

  task automatic t_buffered;
    cnt = 0;
    wr_ctrl(4'b0101, 1);
    wr_val(16'd20);
    wr_ctrl(4'b1001, 1);
    chk("R5 active first", rd_value, 20);
    wr_val(16'd30);
    chk("R5 write deferred", rd_value, 20);
    begin
      logic lvl;
      lvl = pin_out;
      cnt = 30; tick(); cnt = 0;
      chk("R5 no early match", pin_out, lvl);
      cnt_ovf = 1; tick(); cnt_ovf = 0;
      chk("R5 swap at overflow", rd_value, 30);
      cnt = 30; tick(); cnt = 0;
      chk("R5 toggle after swap", pin_out, !lvl);
    end
    wr_val(16'd40);
    chk("R5 second write deferred", rd_value, 30);
    cnt_ovf = 1; tick(); cnt_ovf = 0;
    chk("R5 second swap", rd_value, 40);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    tick(2);
    rst_n = 1;
    tick();
    t_reset();
    t_park();
    t_capture();
    t_compare();
    t_guard();
    t_buffered();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule